// File: doc/BRIEF.md
# Packet Byte-Order Normalising Splitter

The block sits between a packet transport and a transaction engine. Request packets arrive as a stream of 32-bit words with a valid/ready handshake and an end-of-packet marker. The first word of each packet is the packet header. The block masks this word and classifies it. The result is native order, reversed order, or an unknown pattern. The decision applies to every following word of that packet. The packet header is consumed and not forwarded. The remaining words are split into transactions. Each transaction is one header word and a body whose length follows from the type and word-count fields of that header.

Transactions leave on a second handshake stream. Each word carries a flag that marks a transaction header and a flag that marks the last word of a transaction. A packet that ends before its current body is complete raises a one-cycle format-error pulse. An unrecognised packet header raises a one-cycle warning pulse, and that packet then passes unswapped.

On the return path, every response packet gets a packet header placed in front of it. Its words are byte-swapped whenever the most recent request packet was reversed. The block adds no buffering. Words pass combinationally, and back-pressure from each sink reaches its source directly.

Top module: `pkt_order_splitter`

## Requirements
- R1: The first word of each request packet (after reset or after a word accepted with `in_last_i`) is ANDed with 0xF00000F0. A result of 0x200000F0 selects native order, and the words of that packet leave `tx_data_o` unchanged.
- R2: A masked result of 0xF0000020 selects reversed order. Every later word of that packet is byte-swapped on `tx_data_o`: bits [7:0] exchange with [31:24], and [15:8] exchange with [23:16].
- R3: Any other masked result drives `warn_o` high for exactly the one cycle after the packet header is accepted, and that packet is forwarded unswapped.
- R4: The packet header never appears on the transaction stream. While a packet header is expected, `in_ready_o` is high whatever the state of `tx_ready_i`.
- R5: Transaction header fields (after any swap) are type in bits [7:4] and word count N in bits [16:8]. The body length is 1 for type 0 (read) and type 2 (non-incrementing read). It is N+1 for type 1 (write) and type 3 (non-incrementing write), 3 for type 4 (bit-masked read-modify-write), and 2 for type 5 (add read-modify-write). It is 0 for type 8 (byte-order) and for every other type. `tx_hdr_o` marks transaction header words. `tx_last_o` marks the final word of each transaction and the final word of each packet.
- R6: If a word accepted with `in_last_i` leaves the current body incomplete, `fmt_err_o` is high for exactly the next cycle, and the next word is treated as a new packet header.
- R7: No word is lost or duplicated. Outside the packet-header slot, `tx_valid_o` follows `in_valid_i`, `in_ready_o` follows `tx_ready_i`, and the two handshakes coincide.
- R8: Each response packet begins with one inserted word. That word is 0x200000F0, or 0xF0000020 when the swap decision currently held is reversed. While it is shown, `rsp_ready_o` is low and `rsp_last_o` is low.
- R9: Response words after the inserted word carry `rsp_last_i` through. They are byte-swapped exactly when the decision held at the moment the inserted word was accepted was reversed.
- R10: After reset, no transaction is offered, `in_ready_o` is high, both flags are low, and a pending response shows the native header 0x200000F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 32 | Request word |
| in_last_i | input | 1 | Last word of the request packet |
| in_valid_i | input | 1 | Request word valid |
| in_ready_o | output | 1 | Request word accepted |
| tx_data_o | output | 32 | Transaction word, order normalised |
| tx_hdr_o | output | 1 | Word is a transaction header |
| tx_last_o | output | 1 | Last word of a transaction or of the packet |
| tx_valid_o | output | 1 | Transaction word valid |
| tx_ready_i | input | 1 | Transaction sink ready |
| warn_o | output | 1 | Unknown packet header pulse |
| fmt_err_o | output | 1 | Packet ended inside a body pulse |
| rsp_data_i | input | 32 | Response word from the transaction engine |
| rsp_last_i | input | 1 | Last response word of the packet |
| rsp_valid_i | input | 1 | Response word valid |
| rsp_ready_o | output | 1 | Response word accepted |
| rsp_data_o | output | 32 | Outgoing response word |
| rsp_last_o | output | 1 | Last outgoing response word |
| rsp_valid_o | output | 1 | Outgoing response word valid |
| rsp_ready_i | input | 1 | Outgoing response sink ready |

## Verification
The hardest case is the response swap when request and response traffic overlap. The response latches its swap decision when the inserted word is taken. A later request header can change the live decision while a response body is still in flight. The bench drives both streams with independent random valid and ready stalls, and it alternates native and reversed request packets. As a result, packet-header acceptances fall both inside and outside response bodies. Truncation is reached by cutting a packet at a transaction header and in the middle of a body. A long write of several hundred words exercises the wide word-count field.

// File: rtl/pos_pkg.sv
package pos_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] HDR_MASK     = 32'hF000_00F0;
  localparam logic [WORD_W-1:0] HDR_NATIVE   = 32'h2000_00F0;
  localparam logic [WORD_W-1:0] HDR_REVERSED = 32'hF000_0020;

  typedef enum logic [3:0] {
    TK_READ       = 4'd0,
    TK_WRITE      = 4'd1,
    TK_NI_READ    = 4'd2,
    TK_NI_WRITE   = 4'd3,
    TK_RMW_BITS   = 4'd4,
    TK_RMW_SUM    = 4'd5,
    TK_BYTE_ORDER = 4'd8
  } tx_kind_e;

  typedef enum logic [1:0] {
    FR_PKT_HDR,
    FR_TX_HDR,
    FR_BODY
  } fr_state_e;
endpackage

// File: rtl/byte_swap.sv
module byte_swap #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  localparam int unsigned NB = W / 8;
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign out_o[g*8 +: 8] = in_i[(NB-1-g)*8 +: 8];
  end
endmodule

// File: rtl/order_classify.sv
module order_classify
  import pos_pkg::*;
(
  input  logic [WORD_W-1:0] masked_i,
  output logic              swap_o,
  output logic              unknown_o
);
  assign swap_o    = (masked_i == HDR_REVERSED);
  assign unknown_o = !((masked_i == HDR_NATIVE) || (masked_i == HDR_REVERSED));
endmodule

// File: rtl/tx_body_len.sv
module tx_body_len
  import pos_pkg::*;
#(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned LEN_W = CNT_W + 1
) (
  input  logic [3:0]       kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    unique case (kind_i)
      TK_READ, TK_NI_READ:   len_o = LEN_W'(1);
      TK_WRITE, TK_NI_WRITE: len_o = LEN_W'(cnt_i) + LEN_W'(1);
      TK_RMW_BITS:           len_o = LEN_W'(3);
      TK_RMW_SUM:            len_o = LEN_W'(2);
      default:               len_o = '0; // byte-order and unknown kinds
    endcase
  end
endmodule

// File: rtl/rsp_prefix.sv
module rsp_prefix
  import pos_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  input  logic              rsp_last_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              rsp_last_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i
);
  logic              start_q, lswap_q;
  logic [WORD_W-1:0] data_sw, hdr_sw, hdr_word;

  byte_swap #(.W(WORD_W)) u_sw_data (.in_i(rsp_data_i), .out_o(data_sw));
  byte_swap #(.W(WORD_W)) u_sw_hdr  (.in_i(HDR_NATIVE), .out_o(hdr_sw));

  assign hdr_word    = swap_i ? hdr_sw : HDR_NATIVE;
  assign rsp_valid_o = rsp_valid_i;
  assign rsp_data_o  = start_q ? hdr_word : (lswap_q ? data_sw : rsp_data_i);
  assign rsp_last_o  = !start_q && rsp_last_i;
  assign rsp_ready_o = !start_q && rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      lswap_q <= 1'b0;
    end else if (rsp_valid_i && rsp_ready_i) begin
      if (start_q) begin
        start_q <= 1'b0;
        lswap_q <= swap_i; // decision frozen for this response packet
      end else if (rsp_last_i) begin
        start_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_order_splitter.sv
module pkt_order_splitter
  import pos_pkg::*;
#(
  parameter int unsigned CNT_LSB  = 8,
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned KIND_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [WORD_W-1:0] tx_data_o,
  output logic              tx_hdr_o,
  output logic              tx_last_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              warn_o,
  output logic              fmt_err_o,
  input  logic [WORD_W-1:0] rsp_data_i,
  input  logic              rsp_last_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              rsp_last_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i
);
  localparam int unsigned LEN_W = CNT_W + 1;

  fr_state_e         state_q;
  logic [LEN_W-1:0]  rem_q, body_len;
  logic              swap_q, warn_q, err_q;
  logic              cls_swap, cls_unknown, acc;
  logic [WORD_W-1:0] in_sw, word_n;

  order_classify u_cls (
    .masked_i (in_data_i & HDR_MASK),
    .swap_o   (cls_swap),
    .unknown_o(cls_unknown)
  );

  byte_swap #(.W(WORD_W)) u_sw_in (.in_i(in_data_i), .out_o(in_sw));
  assign word_n = swap_q ? in_sw : in_data_i;

  tx_body_len #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_len (
    .kind_i(word_n[KIND_LSB +: 4]),
    .cnt_i (word_n[CNT_LSB +: CNT_W]),
    .len_o (body_len)
  );

  assign in_ready_o = (state_q == FR_PKT_HDR) || tx_ready_i;
  assign tx_valid_o = in_valid_i && (state_q != FR_PKT_HDR);
  assign tx_data_o  = word_n;
  assign tx_hdr_o   = (state_q == FR_TX_HDR);
  assign acc        = in_valid_i && in_ready_o;
  assign warn_o     = warn_q;
  assign fmt_err_o  = err_q;

  always_comb begin
    unique case (state_q)
      FR_TX_HDR: tx_last_o = in_last_i || (body_len == '0);
      FR_BODY:   tx_last_o = in_last_i || (rem_q == LEN_W'(1));
      default:   tx_last_o = in_last_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_PKT_HDR;
      rem_q   <= '0;
      swap_q  <= 1'b0;
      warn_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
      if (acc) begin
        unique case (state_q)
          FR_PKT_HDR: begin
            swap_q  <= cls_swap;
            warn_q  <= cls_unknown;
            state_q <= in_last_i ? FR_PKT_HDR : FR_TX_HDR;
          end
          FR_TX_HDR: begin
            if (in_last_i) begin
              err_q   <= (body_len != '0);
              state_q <= FR_PKT_HDR;
            end else if (body_len != '0) begin
              rem_q   <= body_len;
              state_q <= FR_BODY;
            end
          end
          FR_BODY: begin
            rem_q <= rem_q - 1'b1;
            if (in_last_i) begin
              err_q   <= (rem_q != LEN_W'(1));
              state_q <= FR_PKT_HDR;
            end else if (rem_q == LEN_W'(1)) begin
              state_q <= FR_TX_HDR;
            end
          end
          default: state_q <= FR_PKT_HDR;
        endcase
      end
    end
  end

  rsp_prefix u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .swap_i     (swap_q),
    .rsp_data_i (rsp_data_i),
    .rsp_last_i (rsp_last_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_ready_o(rsp_ready_o),
    .rsp_data_o (rsp_data_o),
    .rsp_last_o (rsp_last_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i)
  );
endmodule

// File: rtl/pkt_order_splitter_chk.sv
module pkt_order_splitter_chk
  import pos_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_last_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              warn_o,
  input logic              fmt_err_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_o,
  input logic              rsp_last_o,
  input logic [WORD_W-1:0] rsp_data_o,
  input logic              rsp_ready_i
);
  logic c_exp_hdr, c_rsp_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_exp_hdr   <= 1'b1;
      c_rsp_start <= 1'b1;
    end else begin
      if (in_valid_i && in_ready_o) c_exp_hdr <= in_last_i;
      if (rsp_valid_o && rsp_ready_i) begin
        if (c_rsp_start) c_rsp_start <= 1'b0;
        else if (rsp_last_o) c_rsp_start <= 1'b1;
      end
    end
  end

  a_r4_pkt_hdr_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && c_exp_hdr) |-> (in_ready_o && !tx_valid_o));

  a_r7_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |-> (in_valid_i && in_ready_o));

  a_r7_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !c_exp_hdr) |-> (tx_valid_o && (in_ready_o == tx_ready_i)));

  a_r3_warn_after_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> $past(in_valid_i && in_ready_o && c_exp_hdr));

  a_r6_err_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> $past(in_valid_i && in_ready_o && in_last_i && !c_exp_hdr));

  a_r8_rsp_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rsp_start && rsp_valid_o) |->
      (!rsp_ready_o && !rsp_last_o &&
       (rsp_data_o == HDR_NATIVE || rsp_data_o == HDR_REVERSED)));

  a_r10_no_spurious_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> in_valid_i);
endmodule

bind pkt_order_splitter pkt_order_splitter_chk u_chk (.*);

// File: tb/pkt_order_splitter_bench.sv
`timescale 1ns/100ps
module pkt_order_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] in_data = '0, rsp_data = '0;
  logic        in_last = 1'b0, in_valid = 1'b0, tx_ready = 1'b0;
  logic        rsp_last = 1'b0, rsp_valid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] tx_data_o, rsp_data_o;
  logic        in_ready_o, tx_hdr_o, tx_last_o, tx_valid_o, warn_o, fmt_err_o;
  logic        rsp_ready_o, rsp_last_o, rsp_valid_o;

  always #2.5 clk = ~clk;

  pkt_order_splitter u_pkt_order_splitter (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_data_i(in_data), .in_last_i(in_last), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .tx_data_o(tx_data_o), .tx_hdr_o(tx_hdr_o), .tx_last_o(tx_last_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready),
    .warn_o(warn_o), .fmt_err_o(fmt_err_o),
    .rsp_data_i(rsp_data), .rsp_last_i(rsp_last), .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready_o),
    .rsp_data_o(rsp_data_o), .rsp_last_o(rsp_last_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready)
  );

  int n_cmp = 0, n_bad = 0;
  logic [32:0] req_q[$];
  logic [32:0] rsp_q[$];
  logic [31:0] build_q[$];
  bit done = 0;

  // reference model state
  bit m_exp_hdr = 1, m_swap = 0, m_warn = 0, m_err = 0;
  int m_rem = 0;
  bit m_rstart = 1, m_rswap = 0;

  function automatic logic [31:0] bs(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic int blen(logic [31:0] h);
    case (h[7:4])
      4'd0, 4'd2: return 1;
      4'd1, 4'd3: return int'(h[16:8]) + 1;
      4'd4:       return 3;
      4'd5:       return 2;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [31:0] mk_hdr(int kind, int n, int id);
    return {4'h2, 11'(id), 9'(n), 4'(kind), 4'h0};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tx_add(int kind, int n);
    int bl;
    build_q.push_back(mk_hdr(kind, n, build_q.size()));
    bl = blen(mk_hdr(kind, n, 0));
    for (int i = 0; i < bl; i++) build_q.push_back(32'hA000_0000 + (kind << 16) + i);
  endtask

  task automatic wait_req_drain();
    while (req_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic send_pkt(logic [31:0] pkt_hdr, bit rev, int cut);
    int sz;
    sz = build_q.size() - cut;
    req_q.push_back({(sz == 0), pkt_hdr});
    for (int i = 0; i < sz; i++)
      req_q.push_back({(i == sz - 1), rev ? bs(build_q[i]) : build_q[i]});
    build_q.delete();
    wait_req_drain();
  endtask

  task automatic send_rsp(int n);
    for (int i = 0; i < n; i++) rsp_q.push_back({(i == n - 1), $urandom()});
  endtask

  // per-cycle compare against the reference model, sampled 0.5 ns before the rising edge
  task automatic step();
    logic [31:0] w, exp_d, hdr_exp;
    bit exp_rdy, exp_last, is_hdr, hs_rsp;
    int bl, nrem;
    // response path first: it sees the decision held before this edge
    hdr_exp = m_swap ? 32'hF000_0020 : 32'h2000_00F0;
    chk(rsp_valid_o == rsp_valid, "R7", "rsp_valid", 32'(rsp_valid_o), 32'(rsp_valid));
    if (rsp_valid) begin
      if (m_rstart) begin
        chk(rsp_data_o == hdr_exp, "R8", "rsp header", rsp_data_o, hdr_exp);
        chk(!rsp_ready_o && !rsp_last_o, "R8", "rsp header stall", {rsp_ready_o, rsp_last_o}, 0);
      end else begin
        exp_d = m_rswap ? bs(rsp_data) : rsp_data;
        chk(rsp_data_o == exp_d, "R9", "rsp data", rsp_data_o, exp_d);
        chk(rsp_last_o == rsp_last, "R9", "rsp last", 32'(rsp_last_o), 32'(rsp_last));
        chk(rsp_ready_o == rsp_ready, "R9", "rsp ready", 32'(rsp_ready_o), 32'(rsp_ready));
      end
    end
    hs_rsp = rsp_valid && rsp_ready && !m_rstart;
    if (rsp_valid && rsp_ready) begin
      if (m_rstart) begin m_rstart = 0; m_rswap = m_swap; end
      else if (rsp_last) m_rstart = 1;
    end
    if (hs_rsp) void'(rsp_q.pop_front());

    // request path
    chk(warn_o == m_warn, "R3", "warn", 32'(warn_o), 32'(m_warn));
    chk(fmt_err_o == m_err, "R6", "fmt_err", 32'(fmt_err_o), 32'(m_err));
    m_warn = 0; m_err = 0;
    exp_rdy = m_exp_hdr ? 1'b1 : tx_ready;
    chk(in_ready_o == exp_rdy, m_exp_hdr ? "R4" : "R7", "in_ready", 32'(in_ready_o), 32'(exp_rdy));
    chk(tx_valid_o == (in_valid && !m_exp_hdr), m_exp_hdr ? "R4" : "R7", "tx_valid",
        32'(tx_valid_o), 32'(in_valid && !m_exp_hdr));
    w = m_swap ? bs(in_data) : in_data;
    is_hdr = (m_rem == 0);
    bl = blen(w);
    if (in_valid && !m_exp_hdr) begin
      chk(tx_data_o == w, m_swap ? "R2" : "R1", "tx_data", tx_data_o, w);
      chk(tx_hdr_o == is_hdr, "R5", "tx_hdr", 32'(tx_hdr_o), 32'(is_hdr));
      exp_last = in_last || (is_hdr ? (bl == 0) : (m_rem == 1));
      chk(tx_last_o == exp_last, "R5", "tx_last", 32'(tx_last_o), 32'(exp_last));
    end
    if (in_valid && exp_rdy) begin
      if (m_exp_hdr) begin
        m_swap = ((in_data & 32'hF000_00F0) == 32'hF000_0020);
        m_warn = !(((in_data & 32'hF000_00F0) == 32'h2000_00F0) || m_swap);
        m_exp_hdr = in_last;
        m_rem = 0;
      end else begin
        nrem = is_hdr ? bl : m_rem - 1;
        if (in_last) begin
          m_err = (nrem > 0);
          m_exp_hdr = 1;
          m_rem = 0;
        end else m_rem = nrem;
      end
      void'(req_q.pop_front());
    end
  endtask

  // reset, drive and compare
  initial begin
    in_valid = 1; in_data = 32'hF000_0020; rsp_valid = 1; rsp_ready = 1; tx_ready = 1;
    #12;
    chk(!tx_valid_o, "R10", "reset tx_valid", 32'(tx_valid_o), 0);
    chk(in_ready_o, "R10", "reset in_ready", 32'(in_ready_o), 1);
    chk(!warn_o && !fmt_err_o, "R10", "reset flags", {warn_o, fmt_err_o}, 0);
    chk(rsp_data_o == 32'h2000_00F0, "R10", "reset rsp header", rsp_data_o, 32'h2000_00F0);
    chk(!rsp_ready_o, "R10", "reset rsp_ready", 32'(rsp_ready_o), 0);
    in_valid = 0; rsp_valid = 0; rsp_ready = 0; tx_ready = 0;
    @(negedge clk);
    rst_ni = 1;
    forever begin
      @(negedge clk);
      in_valid = (req_q.size() > 0) && ($urandom_range(3) != 0);
      {in_last, in_data} = (req_q.size() > 0) ? req_q[0] : 33'd0;
      tx_ready = ($urandom_range(3) != 0);
      rsp_valid = (rsp_q.size() > 0) && ($urandom_range(3) != 0);
      {rsp_last, rsp_data} = (rsp_q.size() > 0) ? rsp_q[0] : 33'd0;
      rsp_ready = ($urandom_range(4) != 0);
      #2;
      step();
    end
  end

  // stimulus
  initial begin
    wait (rst_ni === 1'b1);
    repeat (2) @(posedge clk);
    // native packet with every kind
    tx_add(0, 1); tx_add(1, 3); tx_add(4, 0); tx_add(5, 0); tx_add(8, 0); tx_add(2, 4); tx_add(3, 2);
    send_rsp(4);
    send_pkt(32'h2000_00F0, 0, 0);
    // reversed packet, then a response that must be swapped
    tx_add(1, 2); tx_add(0, 1); tx_add(5, 0); tx_add(9, 5); tx_add(1, 0);
    send_pkt(32'hF000_0020, 1, 0);
    send_rsp(3); send_rsp(1);
    // unknown header: warning, no swap
    tx_add(0, 1); tx_add(4, 0);
    send_pkt(32'h1234_5678, 0, 0);
    // truncated inside a body
    tx_add(0, 1); tx_add(1, 4);
    send_pkt(32'h2000_00F0, 0, 3);
    // truncated right at a transaction header, reversed
    tx_add(4, 0);
    send_pkt(32'hF000_0020, 1, 3);
    send_rsp(2);
    // header-only packet
    send_pkt(32'h2000_00F0, 0, 0);
    // long write, overlapping responses with changing decisions
    tx_add(1, 300); tx_add(0, 1);
    send_rsp(6);
    send_pkt(32'hF000_0020, 1, 0);
    send_rsp(5);
    tx_add(3, 7);
    send_pkt(32'h2000_00F0, 0, 0);
    while (rsp_q.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule